// File: doc/BRIEF.md
# Buck Regulator Start-Up and Protection Sequencer

This block is the supervisory state machine of a single-phase buck controller. Analog comparators outside it report digital flags: two supply-good levels, an enable request, output over-voltage, output under-voltage, two overcurrent severities and an output-below-half-reference indication. From these flags the sequencer produces a reference code for an external DAC, a power-good output and a two-bit gate-drive command for the driver stage.

Every decision is taken on a one-cycle tick from the external switching timer, so all delays are counted in switching periods. A start waits a fixed number of ticks with both gates off. The reference code then climbs one count per tick to full scale. Power-good follows a short settle. Each fault has its own response: a restart, a latch with the low side held on, a latch with both gates off, or a controlled discharge.

Top module: `buck_seq`

## Requirements
- R1: gate_mode encodes 0 = both gates off, 1 = switching, 2 = low side forced on, 3 = discharge. From idle, a tick with both supply flags and enable high starts a hold of DELAY ticks with gate_mode 0 and ref_code 0. The last hold tick switches gate_mode to 1 with ref_code still 0. With either supply flag low, the tick starts nothing.
- R2: During the ramp, every tick adds one to ref_code until it reaches full scale (all ones), with gate_mode 1.
- R3: Power-good rises on the PG_DLY-th tick after the tick on which ref_code reached full scale. It is high only in regulation and only while both uv and ov are low.
- R4: uv has no effect while ref_code is below ARM = floor(full_scale * UV_PCT / 100); the ramp continues unchanged.
- R5: uv seen on a tick during soft-start, once ref_code is at or above ARM or during the power-good wait, returns the machine to the start of the hold: gate_mode 0, ref_code 0, then a full hold and ramp.
- R6: uv on a tick in regulation latches gate_mode 0 and ref_code 0. Only a tick with enable low (to idle) or a supply loss clears the latch.
- R7: oc_lo on a tick while switching restarts from the hold with gate_mode 0. The OC_TRIES-th such event since idle latches gate_mode 0 instead.
- R8: oc_hi on a tick while switching latches gate_mode 0 at once.
- R9: ov on a tick in any active state latches gate_mode 2, power-good low and ref_code 0, until enable is dropped.
- R10: Enable low on a tick in an active state gives gate_mode 3. The first tick with below_half high then returns to idle with gate_mode 0.
- R11: In idle, gate_mode follows ov directly (2 when ov is high, else 0), without waiting for a tick.
- R12: Either supply flag low on a tick returns to idle from any state, clears every latch and clears the overcurrent event count.
- R13: Without a tick, no state, ref_code or latch changes, whatever the fault flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per switching period |
| sup_a_ok | input | 1 | Controller supply above its threshold |
| sup_b_ok | input | 1 | Driver supply above its threshold |
| en | input | 1 | Enable request |
| ov | input | 1 | Output over-voltage flag |
| uv | input | 1 | Output under-voltage flag |
| oc_lo | input | 1 | Lower-level overcurrent flag |
| oc_hi | input | 1 | Upper-level overcurrent flag |
| below_half | input | 1 | Output below half of reference |
| ref_code | output | REF_W | Reference code for the DAC |
| pgood | output | 1 | Power-good |
| gate_mode | output | 2 | Gate-drive command, encoded as in R1 |

## Verification
The bench builds the sequencer with REF_W = 5, DELAY = 4, PG_DLY = 3 and OC_TRIES = 4. This gives a 31-step ramp with the under-voltage arm point at code 24, so every ramp count, the arm boundary and the power-good settle are checked tick by tick. The short hold makes room for four overcurrent restarts, so the latch on the fourth event and the counter clear after a supply loss both fall within the run. Faults are held without a tick to show that only the combinational outputs react.

// File: rtl/buck_seq.sv
module buck_seq #(
  parameter int REF_W    = 10,
  parameter int DELAY    = 64,
  parameter int PG_DLY   = 3,
  parameter int OC_TRIES = 4,
  parameter int UV_PCT   = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sup_a_ok,
  input  logic             sup_b_ok,
  input  logic             en,
  input  logic             ov,
  input  logic             uv,
  input  logic             oc_lo,
  input  logic             oc_hi,
  input  logic             below_half,
  output logic [REF_W-1:0] ref_code,
  output logic             pgood,
  output logic [1:0]       gate_mode
);
  localparam int CW = $clog2((DELAY > PG_DLY ? DELAY : PG_DLY) + 1);
  localparam int OW = $clog2(OC_TRIES + 1);
  localparam int FULL = (1 << REF_W) - 1;
  localparam logic [REF_W-1:0] FULL_C = REF_W'(FULL);
  localparam logic [REF_W-1:0] ARM_C  = REF_W'((FULL * UV_PCT) / 100);

  localparam logic [1:0] G_OFF = 2'd0, G_PWM = 2'd1, G_LOW = 2'd2, G_DIS = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_RAMP, S_PGW, S_RUN, S_DIS, S_LOV, S_LOFF
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [OW-1:0] occ;

  wire sup_ok = sup_a_ok & sup_b_ok;
  wire sw     = (st == S_RAMP) || (st == S_PGW) || (st == S_RUN);
  wire uv_hit = uv && ((st == S_RUN) || (st == S_PGW) ||
                       ((st == S_RAMP) && (ref_code >= ARM_C)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      occ      <= '0;
      ref_code <= '0;
    end else if (tick) begin
      if (!sup_ok) begin
        st       <= S_IDLE;
        cnt      <= '0;
        occ      <= '0;
        ref_code <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            occ <= '0;
            if (en) begin
              st  <= S_HOLD;
              cnt <= '0;
            end
          end
          S_LOV, S_LOFF: if (!en) st <= S_IDLE;
          S_DIS:         if (below_half) st <= S_IDLE;
          default: begin
            if (!en) begin
              st       <= S_DIS;
              ref_code <= '0;
            end else if (ov) begin
              st       <= S_LOV;
              ref_code <= '0;
            end else if (sw && oc_hi) begin
              st       <= S_LOFF;
              ref_code <= '0;
            end else if (sw && oc_lo) begin
              ref_code <= '0;
              if (occ == OW'(OC_TRIES - 1)) st <= S_LOFF;
              else begin
                occ <= occ + 1'b1;
                st  <= S_HOLD;
                cnt <= '0;
              end
            end else if (uv_hit) begin
              ref_code <= '0;
              if (st == S_RUN) st <= S_LOFF;
              else begin
                st  <= S_HOLD;
                cnt <= '0;
              end
            end else begin
              case (st)
                S_HOLD:
                  if (cnt == CW'(DELAY - 1)) begin
                    st       <= S_RAMP;
                    ref_code <= '0;
                  end else cnt <= cnt + 1'b1;
                S_RAMP: begin
                  ref_code <= ref_code + 1'b1;
                  if (ref_code == FULL_C - 1'b1) begin
                    st  <= S_PGW;
                    cnt <= '0;
                  end
                end
                S_PGW:
                  if (cnt == CW'(PG_DLY - 1)) st <= S_RUN;
                  else cnt <= cnt + 1'b1;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign pgood = (st == S_RUN) && !uv && !ov;

  always_comb begin
    case (st)
      S_IDLE:                gate_mode = ov ? G_LOW : G_OFF;
      S_RAMP, S_PGW, S_RUN:  gate_mode = G_PWM;
      S_DIS:                 gate_mode = G_DIS;
      S_LOV:                 gate_mode = G_LOW;
      default:               gate_mode = G_OFF;
    endcase
  end
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
  parameter int REF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sup_a_ok,
  input logic             sup_b_ok,
  input logic             en,
  input logic             ov,
  input logic             uv,
  input logic [REF_W-1:0] ref_code,
  input logic             pgood,
  input logic [1:0]       gate_mode
);
  localparam logic [REF_W-1:0] FULL_C = '1;

  a_r3_pgood_window: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (gate_mode == 2'd1) && !uv && !ov);

  a_r13_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ref_code));

  a_r2_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ref_code != '0 && ref_code != FULL_C) |=>
      (ref_code == $past(ref_code) + 1'b1) || (ref_code == '0));

  a_r9_ov_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ov && en && sup_a_ok && sup_b_ok && gate_mode == 2'd1) |=>
      (gate_mode == 2'd2) && !pgood);

  a_r10_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && sup_a_ok && sup_b_ok && gate_mode == 2'd1) |=> gate_mode == 2'd3);

  a_r12_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(sup_a_ok && sup_b_ok)) |=>
      (ref_code == '0) && !pgood && (gate_mode == 2'd0 || gate_mode == 2'd2));
endmodule

bind buck_seq buck_seq_chk #(.REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok),
  .en(en), .ov(ov), .uv(uv), .ref_code(ref_code), .pgood(pgood), .gate_mode(gate_mode)
);

// File: tb/buck_seq_tb.sv
module buck_seq_tb;
  localparam int RW = 5, DLY = 4, PGD = 3, OCT = 4;
  localparam int FULL = (1 << RW) - 1;
  localparam int ARM = (FULL * 80) / 100;

  logic clk = 0, rst_n = 0, tick = 0;
  logic sup_a_ok = 1, sup_b_ok = 1, en = 0, ov = 0, uv = 0;
  logic oc_lo = 0, oc_hi = 0, below_half = 0;
  logic [RW-1:0] ref_code;
  logic pgood;
  logic [1:0] gate_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [RW-1:0] code;
    logic          pg;
    logic [1:0]    gate;
    string         req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  buck_seq #(.REF_W(RW), .DELAY(DLY), .PG_DLY(PGD), .OC_TRIES(OCT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok),
    .en(en), .ov(ov), .uv(uv), .oc_lo(oc_lo), .oc_hi(oc_hi), .below_half(below_half),
    .ref_code(ref_code), .pgood(pgood), .gate_mode(gate_mode)
  );

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ref_code !== e.code || pgood !== e.pg || gate_mode !== e.gate) begin
          fails++;
          $display("FAIL %s code=%0d/%0d pg=%0b/%0b gate=%0d/%0d (actual/expected)",
                   e.req, ref_code, e.code, pgood, e.pg, gate_mode, e.gate);
        end
      end
    end
  end

  task automatic tk(bit do_tick, int ec, bit ep, int eg, string r);
    exp_t e;
    if (do_tick) begin
      @(negedge clk) tick = 1;
    end
    @(negedge clk) tick = 0;
    e.code = RW'(ec); e.pg = ep; e.gate = 2'(eg); e.req = r;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic hold_ramp(int stop, int uvp);
    for (int i = 0; i < DLY - 1; i++) tk(1, 0, 0, 0, "R1");
    tk(1, 0, 0, 1, "R1");
    for (int c = 1; c <= stop; c++) begin
      uv = (c >= uvp && c < uvp + 4);
      tk(1, c, 0, 1, uv ? "R4" : "R2");
    end
    uv = 0;
    if (stop == FULL)
      for (int k = 1; k <= PGD; k++) tk(1, FULL, k == PGD, 1, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tk(0, 0, 0, 0, "R1");
    ov = 1; tk(0, 0, 0, 2, "R11");
    ov = 0; tk(0, 0, 0, 0, "R11");

    en = 1; sup_b_ok = 0; tk(1, 0, 0, 0, "R1");
    sup_b_ok = 1; tk(1, 0, 0, 0, "R1");
    hold_ramp(FULL, 5);

    uv = 1; repeat (3) tk(0, FULL, 0, 1, "R13");
    uv = 0; tk(0, FULL, 1, 1, "R13");
    oc_hi = 1; repeat (3) tk(0, FULL, 1, 1, "R13");
    oc_hi = 0;

    uv = 1; tk(1, 0, 0, 0, "R6");
    uv = 0; repeat (5) tk(1, 0, 0, 0, "R6");
    en = 0; tk(1, 0, 0, 0, "R6");
    en = 1; tk(1, 0, 0, 0, "R6");
    hold_ramp(ARM, -100);
    uv = 1; tk(1, 0, 0, 0, "R5");
    uv = 0; hold_ramp(FULL, -100);

    ov = 1; tk(1, 0, 0, 2, "R9");
    ov = 0; repeat (3) tk(1, 0, 0, 2, "R9");
    en = 0; tk(1, 0, 0, 0, "R9");

    en = 1; tk(1, 0, 0, 0, "R1");
    hold_ramp(FULL, -100);
    en = 0; tk(1, 0, 0, 3, "R10");
    repeat (2) tk(1, 0, 0, 3, "R10");
    below_half = 1; tk(1, 0, 0, 0, "R10");
    below_half = 0;

    en = 1; tk(1, 0, 0, 0, "R1");
    hold_ramp(FULL, -100);
    for (int k = 1; k < OCT; k++) begin
      oc_lo = 1; tk(1, 0, 0, 0, "R7");
      oc_lo = 0; hold_ramp(FULL, -100);
    end
    oc_lo = 1; tk(1, 0, 0, 0, "R7");
    oc_lo = 0; repeat (6) tk(1, 0, 0, 0, "R7");

    sup_a_ok = 0; tk(1, 0, 0, 0, "R12");
    sup_a_ok = 1; tk(1, 0, 0, 0, "R12");
    hold_ramp(FULL, -100);
    oc_lo = 1; tk(1, 0, 0, 0, "R12");
    oc_lo = 0; hold_ramp(FULL, -100);
    oc_hi = 1; tk(1, 0, 0, 0, "R8");
    oc_hi = 0; repeat (5) tk(1, 0, 0, 0, "R8");

    en = 0; tk(1, 0, 0, 0, "R12");
    en = 1; tk(1, 0, 0, 0, "R12");
    hold_ramp(10, -100);
    sup_b_ok = 0; tk(1, 0, 0, 0, "R12");
    sup_b_ok = 1;

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule